// File: doc/BRIEF.md
# SDRAM Concurrent Auto-Precharge Sequencer

This block sits on the controller side of a multi-bank SDRAM. It turns accepted access requests into READ or WRITE commands that always carry auto precharge. A new access to one bank may cut short a read burst that is still running on another bank. The interrupted bank then begins precharging in the cycle the interrupting command appears on the pins, not at the natural end of its burst. When the interrupting access is a write, the block holds the write back and raises the data mask early. Read data still in flight therefore never meets the first write beat on the bus.

Each bank has its own state machine: idle, read burst, write burst, write recovery and precharge. Each also has a down-counter for the interval in progress. A bank-idle flag per bank tells the row-activation logic when a new ACTIVATE is legal. A read-tag pipeline that is CL stages deep marks every cycle that carries returned read data, and the bank it came from. Tags for beats removed by an interrupt are wiped, so capture logic downstream only sees real data. Requests arrive on a valid/ready port. The requester keeps a request steady until it is accepted.

Top module: `sdr_ap_seq`

## Requirements
- R1: A request is accepted on a clock edge where req_valid and req_ready are both high. In the next cycle the pins carry the command: READ is cs_n=0, ras_n=1, cas_n=0, we_n=1; WRITE is the same with we_n=0. sd_ap=1, and sd_ba and sd_col are taken from the request.
- R2: In every cycle with no accepted request behind it, the pins carry NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1) and sd_ap=0.
- R3: A READ on the pins in cycle V drives rd_valid high, with rd_bank equal to its bank, in cycles V+CL through V+CL+BL-1.
- R4: Suppose a READ to another bank appears in cycle V2 while a read burst is running. The old bank's tags end with cycle V2+CL-1, and from cycle V2+CL the tags carry the new bank.
- R5: A bank whose read burst is cut by a READ or WRITE to another bank in cycle V2 starts precharge in V2. Its bank_idle returns high in exactly cycle V2+T_RP.
- R6: Suppose a write request is first presented in cycle t while read data is still due in cycle t or later. Then sd_dqm is high in cycles t+1 and t+2, and the WRITE appears in cycle t+3. With no read data due, the WRITE appears in t+1 and sd_dqm stays low.
- R7: A WRITE on the pins in cycle W removes every read tag for cycle W and all later cycles.
- R8: If no access cuts it short, a bank read in cycle V goes idle in cycle V+BL+T_RP. A bank written in cycle W goes idle in cycle W+BL+T_WR+T_RP.
- R9: req_ready is low while the requested bank is not idle, and in every cycle of a write data burst (W through W+BL-1).
- R10: During and right after reset the pins carry NOP, and sd_dqm and rd_valid are low. Every bank_idle bit is high, and req_ready is high when no request is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_write | input | 1 | 1 for write, 0 for read |
| req_bank | input | BANK_W | Target bank |
| req_col | input | COL_W | Start column |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank address |
| sd_col | output | COL_W | Column address |
| sd_ap | output | 1 | Auto-precharge address bit |
| sd_dqm | output | 1 | Data mask |
| rd_valid | output | 1 | Read data beat on the bus this cycle |
| rd_bank | output | BANK_W | Bank of the current read beat |
| bank_idle | output | NUM_BANKS | Per-bank idle flag, ACTIVATE allowed |

## Verification
The first pattern is a read followed two cycles later by a read to another bank. It separates correct interrupt timing from a design that lets the old burst run out, or that cuts it off at the command cycle instead of CL cycles later. The second is a read followed at once by a write to another bank. It shows whether the mask leads the write by two cycles and whether the pending read tags are wiped. The third sends back-to-back reads to the same bank, and the fourth a read behind a write. Both expose ready decisions that ignore the precharge or recovery countdown. A long run of mixed requests with varying gaps is then compared cycle by cycle against a timeline model kept in the bench.

// File: rtl/sdr_ap_pkg.sv
// Package: shared types for the concurrent auto-precharge sequencer.
// Assumes: command pins follow the usual active-low SDRAM encoding.
package sdr_ap_pkg;

    // Per-bank lifecycle of an auto-precharge access.
    typedef enum logic [2:0] {
        BK_IDLE = 3'd0,
        BK_RD   = 3'd1,
        BK_WR   = 3'd2,
        BK_WREC = 3'd3,
        BK_PRE  = 3'd4
    } bank_st_e;

    // Command held on the pins for the current cycle.
    typedef enum logic [1:0] {
        OP_NOP = 2'd0,
        OP_RD  = 2'd1,
        OP_WR  = 2'd2
    } op_e;

endpackage

// File: rtl/sdr_ap_bank.sv
// Module: one bank's timing tracker.
// Tracks read burst, write burst, write recovery and precharge with a
// down-counter. A cut from another bank's access ends a read burst at once.
// Assumes: issue_i only when the bank is idle; all intervals are at least 1.
module sdr_ap_bank
    import sdr_ap_pkg::*;
#(
    parameter int BL   = 4,
    parameter int T_RP = 3,
    parameter int T_WR = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     issue_i,
    input  logic     wr_i,
    input  logic     cut_i,
    output bank_st_e st_o
);
    localparam int MAXT  = (BL > T_RP) ? ((BL > T_WR) ? BL : T_WR)
                                       : ((T_RP > T_WR) ? T_RP : T_WR);
    localparam int CNT_W = $clog2(MAXT + 1);

    bank_st_e          st_q;
    logic [CNT_W-1:0]  cnt_q;

    // State and remaining-interval counter for this bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= BK_IDLE;
            cnt_q <= '0;
        end else if (issue_i) begin
            st_q  <= wr_i ? BK_WR : BK_RD;
            cnt_q <= CNT_W'(BL);
        end else if (cut_i && st_q == BK_RD) begin
            st_q  <= BK_PRE;
            cnt_q <= CNT_W'(T_RP);
        end else if (cnt_q == CNT_W'(1)) begin
            case (st_q)
                BK_RD:   begin st_q <= BK_PRE;  cnt_q <= CNT_W'(T_RP); end
                BK_WR:   begin st_q <= BK_WREC; cnt_q <= CNT_W'(T_WR); end
                BK_WREC: begin st_q <= BK_PRE;  cnt_q <= CNT_W'(T_RP); end
                default: begin st_q <= BK_IDLE; cnt_q <= '0;           end
            endcase
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign st_o = st_q;

endmodule

// File: rtl/sdr_ap_rdpipe.sv
// Module: read-beat generator and CL-deep tag delay line.
// A load starts BL beats for the given bank and replaces any running burst;
// beats already issued still come out. A flush wipes every pending beat.
// Assumes: load_i and flush_i are never high together.
module sdr_ap_rdpipe #(
    parameter int BL     = 4,
    parameter int CL     = 3,
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              flush_i,
    input  logic [BANK_W-1:0] bank_i,
    output logic              vld_o,
    output logic [BANK_W-1:0] bank_o,
    output logic              busy_o
);
    localparam int GW = $clog2(BL + 1);

    logic [GW-1:0]     gen_left_q;
    logic [BANK_W-1:0] gen_bank_q;
    logic              beat_now;
    logic [CL-1:0]     p_vld_q;
    logic [BANK_W-1:0] p_bank_q [CL];

    assign beat_now = (gen_left_q != '0);

    // Beat generator: one beat per cycle for BL cycles after a load.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            gen_left_q <= '0;
            gen_bank_q <= '0;
        end else if (load_i) begin
            gen_left_q <= GW'(BL);
            gen_bank_q <= bank_i;
        end else if (beat_now) begin
            gen_left_q <= gen_left_q - GW'(1);
        end
    end

    for (genvar i = 0; i < CL; i++) begin : g_stage
        // Stage i of the tag delay line.
        always_ff @(posedge clk) begin
            if (!rst_n || flush_i) begin
                p_vld_q[i]  <= 1'b0;
                p_bank_q[i] <= '0;
            end else if (i == 0) begin
                p_vld_q[i]  <= beat_now;
                p_bank_q[i] <= gen_bank_q;
            end else begin
                p_vld_q[i]  <= p_vld_q[(i == 0) ? 0 : i - 1];
                p_bank_q[i] <= p_bank_q[(i == 0) ? 0 : i - 1];
            end
        end
    end

    assign vld_o  = p_vld_q[CL-1];
    assign bank_o = p_bank_q[CL-1];
    assign busy_o = beat_now || (|p_vld_q);

endmodule

// File: rtl/sdr_ap_seq.sv
// Module: concurrent auto-precharge command sequencer (top).
// Accepts read/write requests and issues them with auto precharge. Lets an
// access to one bank cut a running read burst on another. Holds a write back
// two cycles behind a raised mask while read data is still due.
// Assumes: the requester keeps a request stable until accepted; rows are
// opened by other logic, which uses bank_idle to time ACTIVATE.
module sdr_ap_seq
    import sdr_ap_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int COL_W     = 10,
    parameter int BL        = 4,
    parameter int CL        = 3,
    parameter int T_RP      = 3,
    parameter int T_WR      = 2,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic [BANK_W-1:0]    req_bank,
    input  logic [COL_W-1:0]     req_col,
    output logic                 sd_cs_n,
    output logic                 sd_ras_n,
    output logic                 sd_cas_n,
    output logic                 sd_we_n,
    output logic [BANK_W-1:0]    sd_ba,
    output logic [COL_W-1:0]     sd_col,
    output logic                 sd_ap,
    output logic                 sd_dqm,
    output logic                 rd_valid,
    output logic [BANK_W-1:0]    rd_bank,
    output logic [NUM_BANKS-1:0] bank_idle
);
    bank_st_e          bank_st [NUM_BANKS];
    logic              accept;
    logic              wr_busy;
    logic              rd_busy;
    logic              target_idle;
    logic              wait_cond;
    logic [1:0]        wcnt_q;
    op_e               op_q;
    logic [BANK_W-1:0] ba_q;
    logic [COL_W-1:0]  col_q;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        sdr_ap_bank #(.BL(BL), .T_RP(T_RP), .T_WR(T_WR)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .issue_i (accept && req_bank == BANK_W'(b)),
            .wr_i    (req_write),
            .cut_i   (accept && req_bank != BANK_W'(b)),
            .st_o    (bank_st[b])
        );
        assign bank_idle[b] = (bank_st[b] == BK_IDLE);
    end

    // Any bank still receiving write data blocks new accesses.
    always_comb begin
        wr_busy = 1'b0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_st[b] == BK_WR) wr_busy = 1'b1;
        end
    end

    sdr_ap_rdpipe #(.BL(BL), .CL(CL), .BANK_W(BANK_W)) u_rdpipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (accept && !req_write),
        .flush_i (accept && req_write),
        .bank_i  (req_bank),
        .vld_o   (rd_valid),
        .bank_o  (rd_bank),
        .busy_o  (rd_busy)
    );

    assign target_idle = bank_idle[req_bank];
    assign wait_cond   = req_valid && req_write && rd_busy && target_idle && !wr_busy;
    assign req_ready   = target_idle && !wr_busy &&
                         (!req_write || !rd_busy || wcnt_q == 2'd2);
    assign accept      = req_valid && req_ready;
    assign sd_dqm      = (wcnt_q != 2'd0);

    // Mask lead counter: counts the cycles a write has waited behind read data.
    always_ff @(posedge clk) begin
        if (!rst_n || accept || !wait_cond) begin
            wcnt_q <= 2'd0;
        end else if (wcnt_q != 2'd2) begin
            wcnt_q <= wcnt_q + 2'd1;
        end
    end

    // Command register: loads on accept, otherwise falls back to NOP.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q  <= OP_NOP;
            ba_q  <= '0;
            col_q <= '0;
        end else if (accept) begin
            op_q  <= req_write ? OP_WR : OP_RD;
            ba_q  <= req_bank;
            col_q <= req_col;
        end else begin
            op_q  <= OP_NOP;
        end
    end

    // Pin encoding of the held command.
    always_comb begin
        sd_cs_n  = 1'b0;
        sd_ras_n = 1'b1;
        sd_cas_n = 1'b1;
        sd_we_n  = 1'b1;
        case (op_q)
            OP_RD:   sd_cas_n = 1'b0;
            OP_WR:   begin sd_cas_n = 1'b0; sd_we_n = 1'b0; end
            default: ;
        endcase
    end

    assign sd_ap  = (op_q != OP_NOP);
    assign sd_ba  = ba_q;
    assign sd_col = col_q;

endmodule

// File: rtl/sdr_ap_seq_chk.sv
// Module: property checker for sdr_ap_seq, attached by bind.
// Assumes: port names match the signals of the top module's scope.
module sdr_ap_seq_chk
    import sdr_ap_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic                 req_write,
    input logic [BANK_W-1:0]    req_bank,
    input logic                 sd_cs_n,
    input logic                 sd_ras_n,
    input logic                 sd_cas_n,
    input logic                 sd_we_n,
    input logic [BANK_W-1:0]    sd_ba,
    input logic                 sd_ap,
    input logic                 sd_dqm,
    input logic                 rd_valid,
    input logic [NUM_BANKS-1:0] bank_idle,
    input bank_st_e             bank_st [NUM_BANKS],
    input logic                 rd_busy
);
    logic wr_any;

    // Any bank currently in its write data burst.
    always_comb begin
        wr_any = 1'b0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_st[b] == BK_WR) wr_any = 1'b1;
        end
    end

    // R1: accepted request becomes a column command with auto precharge.
    a_r1_access_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!sd_cs_n && sd_ras_n && !sd_cas_n && sd_ap &&
                                      (sd_we_n == !$past(req_write))))
        else $error("R1 access did not follow accept");

    // R2: no accept means NOP next cycle.
    a_r2_nop_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> (!sd_cs_n && sd_ras_n && sd_cas_n && sd_we_n && !sd_ap))
        else $error("R2 non-NOP without accept");

    // R5: a bank in read burst is precharging once another bank's access shows.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cut
        a_r5_cut_precharges: assert property (@(posedge clk) disable iff (!rst_n)
            (!sd_cas_n && sd_ba != BANK_W'(b) && $past(bank_st[b]) == BK_RD)
                |-> (bank_st[b] == BK_PRE))
            else $error("R5 cut bank not precharging");
    end

    // R6: a write behind pending read data had the mask up two cycles earlier.
    a_r6_dqm_leads_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!sd_cas_n && !sd_we_n && $past(rd_busy)) |-> $past(sd_dqm, 2))
        else $error("R6 mask did not lead write");

    // R7: no read tag while write data is on the bus.
    a_r7_no_tag_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_any |-> !rd_valid)
        else $error("R7 read tag during write burst");

    // R9: accept only towards an idle bank.
    a_r9_accept_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> bank_idle[req_bank])
        else $error("R9 accept to busy bank");

endmodule

bind sdr_ap_seq sdr_ap_seq_chk #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_chk (.*);

// File: tb/sdr_ap_seq_bench.sv
// Bench: timeline reference model compared against the outputs every cycle,
// plus directed checks on the interrupt corner cases.
module sdr_ap_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NB    = 4;
    localparam int BW    = 2;
    localparam int COL_W = 10;
    localparam int BL    = 4;
    localparam int CL    = 3;
    localparam int T_RP  = 3;
    localparam int T_WR  = 2;
    localparam int MAXC  = 4096;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_write = 1'b0;
    logic [BW-1:0] req_bank = '0;
    logic [COL_W-1:0] req_col = '0;
    logic req_ready, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_ap, sd_dqm, rd_valid;
    logic [BW-1:0] sd_ba, rd_bank;
    logic [COL_W-1:0] sd_col;
    logic [NB-1:0] bank_idle;

    sdr_ap_seq #(.NUM_BANKS(NB), .COL_W(COL_W), .BL(BL), .CL(CL),
                 .T_RP(T_RP), .T_WR(T_WR)) u_sdr_ap_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_bank(req_bank), .req_col(req_col),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_ba(sd_ba), .sd_col(sd_col), .sd_ap(sd_ap), .sd_dqm(sd_dqm),
        .rd_valid(rd_valid), .rd_bank(rd_bank), .bank_idle(bank_idle)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_err = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h cycle=%0d", tag, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // Reference timeline: bank of the read beat due in each cycle (-1 none).
    int beat [MAXC];
    int idle_at [NB];
    int rd_end [NB];
    int wr_end = 0;
    int mw = 0;
    int nxt_op = 0;
    int nxt_bank = 0;
    int nxt_col = 0;

    function automatic bit rd_busy_at(input int t);
        for (int k = t; k <= t + CL + BL; k++) begin
            if (k < MAXC && beat[k] >= 0) return 1'b1;
        end
        return 1'b0;
    endfunction

    task automatic model_accept(input int v, input bit w, input int b);
        for (int y = 0; y < NB; y++) begin
            if (y != b && v < rd_end[y]) begin
                idle_at[y] = v + T_RP;
                rd_end[y] = v;
            end
        end
        for (int k = (w ? v : v + CL); k <= v + CL + BL; k++) begin
            if (k < MAXC) beat[k] = -1;
        end
        if (w) begin
            idle_at[b] = v + BL + T_WR + T_RP;
            wr_end = v + BL;
        end else begin
            idle_at[b] = v + BL + T_RP;
            rd_end[b] = v + BL;
            for (int i = 0; i < BL; i++) begin
                if (v + CL + i < MAXC) beat[v + CL + i] = b;
            end
        end
    endtask

    // Per-cycle comparison against the timeline model.
    always @(negedge clk) begin : mon
        int t;
        bit busy, iok, wok, exp_rdy, acc, cond;
        logic [4:0] exp_pins;
        if (rst_n) begin
            t = cyc;
            exp_pins = (nxt_op == 1) ? 5'b01011 : (nxt_op == 2) ? 5'b01001 : 5'b01110;
            if (nxt_op != 0) begin
                check("R1 command pins", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_ap}, exp_pins);
                check("R1 command bank", sd_ba, nxt_bank);
                check("R1 command column", sd_col, nxt_col);
            end else begin
                check("R2 nop pins", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_ap}, exp_pins);
            end
            check("R3 read tag valid", rd_valid, beat[t] >= 0);
            if (beat[t] >= 0) check("R3 read tag bank", rd_bank, beat[t]);
            busy = rd_busy_at(t);
            iok = idle_at[req_bank] <= t;
            wok = t >= wr_end;
            exp_rdy = iok && wok && (!req_write || !busy || mw == 2);
            check("R6 dqm", sd_dqm, mw != 0);
            check("R9 ready", req_ready, exp_rdy);
            for (int b = 0; b < NB; b++) check("R8 bank idle", bank_idle[b], idle_at[b] <= t);
            acc = req_valid && exp_rdy;
            cond = req_valid && req_write && busy && iok && wok;
            mw = acc ? 0 : (cond ? ((mw < 2) ? mw + 1 : 2) : 0);
            if (acc) begin
                model_accept(t + 1, req_write, int'(req_bank));
                nxt_op = req_write ? 2 : 1;
                nxt_bank = int'(req_bank);
                nxt_col = int'(req_col);
            end else begin
                nxt_op = 0;
            end
        end
    end

    // Present a request and return the cycle its command is on the pins.
    task automatic send(input bit w, input int b, input int c, output int v);
        @(posedge clk); #1;
        req_valid = 1'b1;
        req_write = w;
        req_bank = BW'(b);
        req_col = COL_W'(c);
        do @(negedge clk); while (!req_ready);
        @(posedge clk); #1;
        v = cyc;
        req_valid = 1'b0;
    endtask

    // Wait for the sampling point of cycle c (cycles must be increasing).
    task automatic at(input int c);
        do @(negedge clk); while (cyc < c);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_err++;
        n_chk++;
        $display("FAIL R1 watchdog expired: actual=hung expected=done");
        finish_run();
    end

    initial begin
        int v0, v1, w;
        logic [31:0] rs;
        for (int k = 0; k < MAXC; k++) beat[k] = -1;
        for (int b = 0; b < NB; b++) begin idle_at[b] = 0; rd_end[b] = 0; end

        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 reset pins", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_ap}, 5'b01110);
        check("R10 reset dqm", sd_dqm, 0);
        check("R10 reset rd_valid", rd_valid, 0);
        check("R10 reset bank_idle", bank_idle, 4'hF);
        check("R10 reset ready", req_ready, 1);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        check("R10 after reset pins", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_ap}, 5'b01110);

        // Read interrupted by a read to another bank.
        send(0, 0, 16, v0);
        send(0, 1, 32, v1);
        check("R4 interrupt spacing", v1 - v0, 2);
        at(v0 + CL);
        check("R4 first beat old bank", {rd_valid, rd_bank}, {1'b1, 2'd0});
        at(v0 + CL + 1);
        check("R4 second beat old bank", {rd_valid, rd_bank}, {1'b1, 2'd0});
        check("R5 cut bank still precharging", bank_idle[0], 0);
        at(v1 + CL);
        check("R4 first beat new bank", {rd_valid, rd_bank}, {1'b1, 2'd1});
        check("R5 cut bank idle after T_RP", bank_idle[0], 1);
        at(v1 + BL + T_RP + 2);

        // Read interrupted by a write to another bank.
        send(0, 2, 100, v0);
        fork
            send(1, 3, 200, w);
            begin
                at(v0 + 2);
                check("R6 dqm raised early", sd_dqm, 1);
                check("R6 write held back", req_ready, 0);
                at(v0 + 3);
                check("R3 beat before write", {rd_valid, rd_bank}, {1'b1, 2'd2});
            end
        join
        check("R6 write three cycles after request", w, v0 + 4);
        at(w);
        check("R7 tag cleared at write", rd_valid, 0);
        check("R6 dqm low at write", sd_dqm, 0);
        at(w + 1);
        check("R7 tag cleared after write", rd_valid, 0);
        at(w + BL + T_WR + T_RP - 1);
        check("R8 write bank recovering", bank_idle[3], 0);
        at(w + BL + T_WR + T_RP);
        check("R8 write bank idle", bank_idle[3], 1);

        // Back-to-back reads to one bank.
        send(0, 1, 50, v0);
        send(0, 1, 60, v1);
        check("R9 same bank waits for idle", v1, v0 + BL + T_RP + 1);
        at(v1 + BL + T_RP + 3);

        // Write with no read pending, then a read behind it.
        send(1, 0, 5, w);
        check("R6 no dqm on free bus", sd_dqm, 0);
        send(0, 2, 6, v1);
        check("R9 read waits for write burst", v1, w + BL + 1);
        at(v1 + 12);

        // Mixed traffic against the model.
        rs = 32'h1234_5678;
        for (int n = 0; n < 80; n++) begin
            rs = rs * 32'd1103515245 + 32'd12345;
            repeat (int'(rs[20:19])) @(posedge clk);
            send(rs[24], int'(rs[27:26]), int'(rs[17:8]), v0);
        end
        repeat (30) @(posedge clk);
        finish_run();
    end

endmodule